// File: doc/BRIEF.md
# Resumable Munch-Granular Word Mover

This block either copies a run of words from one memory region to another or stamps a single value into every word of a destination region. The caller hands it three arguments. The first argument is the word just before the first source word; in fill mode the same argument carries the fill value. The second is the address of the last destination word. The third is the word count with its sign flipped. The block derives both start addresses from these and walks both regions upward, one word at a time. It uses a request/ready handshake for reads and for writes.

The transfer is cut into munches of 16 words. First comes a head chunk of (count mod 16) words, which may be empty, and then whole munches follow. At the start of every chunk that is not the final one, the block emits prefetch strobes aimed 32 words beyond the chunk's start. In copy mode there is one strobe for the source and then one for the destination. The interrupt request is looked at only when a chunk ends.

If the interrupt request is high at that point, the block stops early. It hands back a rewritten source argument and negative count, so issuing the same operation again with those values finishes exactly the remaining words. On normal completion it hands back a count of zero.

Top module: `blk_mover`

## Requirements
- R1: The first word read is at address a+1, where a is the source argument. The first word written is at last_dst + ncount + 1, where ncount is the negative count argument. Each later read and each later write uses the previous address plus one, with 16-bit wraparound. A completed transfer writes exactly -ncount words.
- R2: In copy mode (mode input 0), the k-th word written carries the data returned by the k-th read.
- R3: In fill mode (mode input 1), no read request is raised, every word written equals the argument a, and a is returned unchanged as the result source argument.
- R4: The head chunk holds (count mod 16) words and every later chunk holds 16. At the start of each chunk after which words remain, a prefetch strobe is raised for chunk-start + 32. In copy mode the source address comes first and the destination address follows in the next cycle. In fill mode only the destination address is strobed. A call that completes without interruption therefore raises floor(count/16) strobes per strobed region.
- R5: The interrupt input is sampled only at chunk ends. An interrupted call always stops with the number of words still to move a multiple of 16.
- R6: When it stops early, the block flags the stop with `done_intr` high together with `done`. In copy mode it returns the address of the last word read as the source result; in fill mode it returns a. It returns minus the number of remaining words as the count result and the last destination argument unchanged. A reissue with these results finishes the transfer.
- R7: On normal completion, `done` pulses with `done_intr` low. The count result is 0 and the last destination result is unchanged. In copy mode the source result is the last source address plus one.
- R8: A count of zero raises no read, write or prefetch. `done` appears by the second clock edge after `start`, and the source result equals a. While idle, including after reset, no request or strobe is raised.
- R9: A read or write request, once raised, keeps its address (and write data) stable until ready is seen. Reads and writes are never requested in the same cycle.
- R10: `start` and the arguments are ignored while the block is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| fill_mode | input | 1 | 0 = copy, 1 = fill |
| arg_a | input | W | Source start minus one (copy) or fill value (fill) |
| arg_dst_last | input | W | Address of the last destination word |
| arg_ncount | input | W | Negated word count |
| irq | input | 1 | Interrupt pending, honoured at chunk ends |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| done_intr | output | 1 | With done: operation stopped early |
| res_a | output | W | Result source argument / fill value |
| res_dst_last | output | W | Result last destination argument |
| res_ncount | output | W | Result negated remaining count |
| rd_valid | output | 1 | Read request |
| rd_addr | output | W | Read address |
| rd_ready | input | 1 | Read accepted; rd_data valid this cycle |
| rd_data | input | W | Read data |
| wr_valid | output | 1 | Write request |
| wr_addr | output | W | Write address |
| wr_data | output | W | Write data |
| wr_ready | input | 1 | Write accepted |
| pf_strobe | output | 1 | Prefetch hint strobe |
| pf_addr | output | W | Prefetch hint address |

## Verification
A bad pointer or chunk counter shows up on the very next accepted read or write as a wrong address or a wrong data word. It also shows up one cycle into a chunk as a misplaced prefetch address. A bad remaining-word count shows up at the next chunk end, either as an interrupt outside the 16-word grid or as a wrong count or source result at `done`. The resumed calls then expose any drift, because every word of the transfer is checked against its one fixed expected address and value across the reissues.

// File: rtl/blk_mover_pkg.sv
package blk_mover_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_HEAD, S_PFD, S_STEP, S_RD, S_WR, S_BND, S_FIN
    } mv_state_e;
endpackage

// File: rtl/blk_mover_setup.sv
module blk_mover_setup #(
    parameter int W        = 16,
    parameter int MUNCH_LG = 4
) (
    input  logic [W-1:0]        arg_a,
    input  logic [W-1:0]        arg_dst_last,
    input  logic [W-1:0]        arg_ncount,
    output logic [W-1:0]        first_src,
    output logic [W-1:0]        first_dst,
    output logic [W-1:0]        total,
    output logic [MUNCH_LG:0]   head
);
    always_comb begin
        first_src = arg_a + W'(1);
        first_dst = arg_dst_last + arg_ncount + W'(1);
        total     = W'(0) - arg_ncount;
        head      = {1'b0, total[MUNCH_LG-1:0]};
    end
endmodule

// File: rtl/blk_mover_resume.sv
module blk_mover_resume #(
    parameter int W = 16
) (
    input  logic         fill,
    input  logic [W-1:0] val,
    input  logic [W-1:0] src_next,
    input  logic [W-1:0] left,
    output logic [W-1:0] stop_src,
    output logic [W-1:0] stop_ncount,
    output logic [W-1:0] end_src
);
    always_comb begin
        stop_src    = fill ? val : src_next - W'(1);
        stop_ncount = W'(0) - left;
        end_src     = fill ? val : src_next;
    end
endmodule

// File: rtl/blk_mover.sv
module blk_mover #(
    parameter int W        = 16,
    parameter int MUNCH_LG = 4,
    parameter int AHEAD    = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         fill_mode,
    input  logic [W-1:0] arg_a,
    input  logic [W-1:0] arg_dst_last,
    input  logic [W-1:0] arg_ncount,
    input  logic         irq,
    output logic         busy,
    output logic         done,
    output logic         done_intr,
    output logic [W-1:0] res_a,
    output logic [W-1:0] res_dst_last,
    output logic [W-1:0] res_ncount,
    output logic         rd_valid,
    output logic [W-1:0] rd_addr,
    input  logic         rd_ready,
    input  logic [W-1:0] rd_data,
    output logic         wr_valid,
    output logic [W-1:0] wr_addr,
    output logic [W-1:0] wr_data,
    input  logic         wr_ready,
    output logic         pf_strobe,
    output logic [W-1:0] pf_addr
);
    import blk_mover_pkg::*;

    localparam int CW    = MUNCH_LG + 1;
    localparam int MUNCH = 1 << MUNCH_LG;
    localparam int PF_D  = AHEAD * MUNCH;

    typedef struct packed {
        mv_state_e    st;
        logic         fill;
        logic [W-1:0] src;
        logic [W-1:0] dst;
        logic [W-1:0] left;
        logic [CW-1:0] chunk;
        logic [W-1:0] dat;
        logic [W-1:0] val;
        logic [W-1:0] dstl;
        logic [W-1:0] res_src;
        logic [W-1:0] res_nc;
        logic         intr;
    } mv_regs_t;

    mv_regs_t q, d;

    logic [W-1:0]  first_src, first_dst, total;
    logic [CW-1:0] head;
    logic [W-1:0]  stop_src, stop_nc, end_src;

    blk_mover_setup #(.W(W), .MUNCH_LG(MUNCH_LG)) u_setup (
        .arg_a        (arg_a),
        .arg_dst_last (arg_dst_last),
        .arg_ncount   (arg_ncount),
        .first_src    (first_src),
        .first_dst    (first_dst),
        .total        (total),
        .head         (head)
    );

    blk_mover_resume #(.W(W)) u_resume (
        .fill        (q.fill),
        .val         (q.val),
        .src_next    (q.src),
        .left        (q.left),
        .stop_src    (stop_src),
        .stop_ncount (stop_nc),
        .end_src     (end_src)
    );

    always_comb begin
        d         = q;
        rd_valid  = 1'b0;
        wr_valid  = 1'b0;
        pf_strobe = 1'b0;
        pf_addr   = q.dst + W'(PF_D);
        rd_addr   = q.src;
        wr_addr   = q.dst;
        wr_data   = q.fill ? q.val : q.dat;
        unique case (q.st)
            S_IDLE: begin
                if (start) begin
                    d.fill    = fill_mode;
                    d.src     = first_src;
                    d.dst     = first_dst;
                    d.left    = total;
                    d.chunk   = head;
                    d.val     = arg_a;
                    d.dstl    = arg_dst_last;
                    d.res_src = arg_a;
                    d.res_nc  = '0;
                    d.intr    = 1'b0;
                    d.st      = (total == '0) ? S_FIN : S_HEAD;
                end
            end
            S_HEAD: begin
                if (q.left != W'(q.chunk)) begin
                    pf_strobe = 1'b1;
                    pf_addr   = q.fill ? q.dst + W'(PF_D) : q.src + W'(PF_D);
                    d.st      = q.fill ? S_STEP : S_PFD;
                end else begin
                    d.st = S_STEP;
                end
            end
            S_PFD: begin
                pf_strobe = 1'b1;
                d.st      = S_STEP;
            end
            S_STEP: begin
                if (q.chunk == '0)  d.st = S_BND;
                else if (q.fill)    d.st = S_WR;
                else                d.st = S_RD;
            end
            S_RD: begin
                rd_valid = 1'b1;
                if (rd_ready) begin
                    d.dat = rd_data;
                    d.src = q.src + W'(1);
                    d.st  = S_WR;
                end
            end
            S_WR: begin
                wr_valid = 1'b1;
                if (wr_ready) begin
                    d.dst   = q.dst + W'(1);
                    d.chunk = q.chunk - CW'(1);
                    d.left  = q.left - W'(1);
                    d.st    = S_STEP;
                end
            end
            S_BND: begin
                if (q.left == '0) begin
                    d.res_src = end_src;
                    d.res_nc  = '0;
                    d.st      = S_FIN;
                end else if (irq) begin
                    d.intr    = 1'b1;
                    d.res_src = stop_src;
                    d.res_nc  = stop_nc;
                    d.st      = S_FIN;
                end else begin
                    d.chunk = CW'(MUNCH);
                    d.st    = S_HEAD;
                end
            end
            S_FIN: begin
                d.st = S_IDLE;
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy         = (q.st != S_IDLE);
    assign done         = (q.st == S_FIN);
    assign done_intr    = q.intr;
    assign res_a        = q.res_src;
    assign res_dst_last = q.dstl;
    assign res_ncount   = q.res_nc;
endmodule

// File: rtl/blk_mover_chk.sv
module blk_mover_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         busy,
    input logic         done,
    input logic         done_intr,
    input logic [W-1:0] res_ncount,
    input logic         rd_valid,
    input logic [W-1:0] rd_addr,
    input logic         rd_ready,
    input logic         wr_valid,
    input logic [W-1:0] wr_addr,
    input logic [W-1:0] wr_data,
    input logic         wr_ready,
    input logic         pf_strobe
);
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr)); // R9
    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data)); // R9
    AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid && wr_valid)); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !rd_valid && !wr_valid && !pf_strobe); // R8
    AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R7
    AST_END_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        done && !done_intr |-> res_ncount == '0); // R7
    AST_STOP_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        done && done_intr |-> res_ncount != '0); // R6
endmodule

bind blk_mover blk_mover_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .done       (done),
    .done_intr  (done_intr),
    .res_ncount (res_ncount),
    .rd_valid   (rd_valid),
    .rd_addr    (rd_addr),
    .rd_ready   (rd_ready),
    .wr_valid   (wr_valid),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .wr_ready   (wr_ready),
    .pf_strobe  (pf_strobe)
);

// File: tb/blk_mover_test.sv
module blk_mover_test;
    localparam int W      = 16;
    localparam int CLK_NS = 10;

    logic clk = 1'b0;
    always #(CLK_NS/2) clk = ~clk;

    logic         rst_n = 1'b0, start = 1'b0, fill_mode = 1'b0, irq = 1'b0;
    logic [W-1:0] arg_a = '0, arg_dst_last = '0, arg_ncount = '0;
    logic         busy, done, done_intr, rd_valid, wr_valid, pf_strobe;
    logic         rd_ready = 1'b0, wr_ready = 1'b0;
    logic [W-1:0] res_a, res_dst_last, res_ncount, rd_addr, rd_data;
    logic [W-1:0] wr_addr, wr_data, pf_addr;

    blk_mover #(.W(W)) uut (.*);

    function automatic logic [W-1:0] pat(logic [W-1:0] a);
        return W'(a * 16'h9e37) ^ 16'h5a5a;
    endfunction
    assign rd_data = pat(rd_addr);

    int vec = 0, bad = 0, cyc = 0, irq_mode = 0;
    int rk, wk, pfn;
    logic         exp_fill;
    logic [W-1:0] exp_val, exp_src0, exp_dst0;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        vec++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        logic [W-1:0] e;
        @(negedge clk);
        cyc++;
        rd_ready = ($urandom % 4) != 0;
        wr_ready = ($urandom % 4) != 0;
        irq = (irq_mode == 1) ? 1'b1 : (irq_mode == 2) ? (($urandom % 8) == 0) : 1'b0;
        #1;
        if (rd_valid && rd_ready) begin
            chk(!exp_fill, "R3", "read raised in fill", 1, 0);
            e = W'(exp_src0 + W'(rk));
            chk(rd_addr == e, "R1", "read address", rd_addr, e);
            rk++;
        end
        if (wr_valid && wr_ready) begin
            e = W'(exp_dst0 + W'(wk));
            chk(wr_addr == e, "R1", "write address", wr_addr, e);
            e = exp_fill ? exp_val : pat(W'(exp_src0 + W'(wk)));
            chk(wr_data == e, exp_fill ? "R3" : "R2", "write data", wr_data, e);
            wk++;
        end
        if (pf_strobe) begin
            e = (exp_fill || pfn[0]) ? W'(exp_dst0 + W'(wk) + W'(32))
                                     : W'(exp_src0 + W'(rk) + W'(32));
            chk(pf_addr == e, "R4", "prefetch address", pf_addr, e);
            pfn++;
        end
    endtask

    logic         r_intr;
    logic [W-1:0] r_a, r_dl, r_nc;
    int           r_ticks;

    task automatic call(logic f, logic [W-1:0] a, logic [W-1:0] dl,
                        logic [W-1:0] nc, int im, bit poke);
        int g;
        pfn = 0;
        irq_mode = im;
        fill_mode = f; arg_a = a; arg_dst_last = dl; arg_ncount = nc;
        start = 1'b1;
        tick();
        start = 1'b0;
        g = 1;
        while (!done && g < 4000) begin
            if (poke && g == 4) begin
                start = 1'b1; fill_mode = ~f; arg_a = ~a;
                arg_dst_last = ~dl; arg_ncount = 16'hfff0;
            end
            tick();
            start = 1'b0;
            g++;
        end
        chk(done, "R7", "done seen before watchdog", int'(done), 1);
        r_ticks = g; r_intr = done_intr; r_a = res_a; r_dl = res_dst_last; r_nc = res_ncount;
        irq_mode = 0;
        tick();
    endtask

    task automatic transfer(logic f, logic [W-1:0] a, logic [W-1:0] dl, int n, int im, bit poke);
        logic [W-1:0] ca, cnc, e;
        int calls, wstart;
        exp_fill = f; exp_val = a;
        exp_src0 = W'(a + W'(1)); exp_dst0 = W'(dl - W'(n) + W'(1));
        rk = 0; wk = 0; ca = a; cnc = W'(-n); calls = 0;
        do begin
            wstart = wk;
            call(f, ca, dl, cnc, (calls < 8) ? im : 0, poke && calls == 0);
            chk(r_dl == dl, "R10", "last destination result", r_dl, dl);
            if (r_intr) begin
                chk(im != 0, "R5", "stop without irq", 1, 0);
                chk(((n - wk) % 16) == 0, "R5", "stop off munch grid", n - wk, 0);
                e = W'(-(n - wk));
                chk(r_nc == e, "R6", "count after stop", r_nc, e);
                e = f ? a : W'(a + W'(wk));
                chk(r_a == e, "R6", "source after stop", r_a, e);
                ca = r_a; cnc = r_nc;
            end else begin
                chk(r_nc == 0, "R7", "count at end", r_nc, 0);
                e = (f || n == 0) ? a : W'(a + W'(n) + W'(1));
                chk(r_a == e, "R7", "source at end", r_a, e);
                chk(wk == n, "R1", "words written", wk, n);
                e = W'(((n - wstart) / 16) * (f ? 1 : 2));
                chk(pfn == int'(e), "R4", "prefetch count", pfn, e);
            end
            calls++;
        end while (r_intr && calls < 40);
        if (f) chk(rk == 0, "R3", "reads in fill", rk, 0);
        else   chk(rk == n, "R2", "reads in copy", rk, n);
    endtask

    initial begin
        exp_fill = 0; exp_val = 0; exp_src0 = 0; exp_dst0 = 0; rk = 0; wk = 0; pfn = 0;
        void'($urandom(32'd1234));
        repeat (3) tick();
        chk(!busy && !done && !rd_valid && !wr_valid && !pf_strobe, "R8",
            "quiet in reset", int'(busy), 0);
        rst_n = 1'b1;
        tick();
        chk(!busy && !rd_valid && !wr_valid && !pf_strobe, "R8", "quiet after reset", int'(busy), 0);

        transfer(0, 16'h1000, 16'h2000, 0, 0, 0);
        chk(r_ticks <= 2 && pfn == 0 && wk == 0, "R8", "zero count", r_ticks, 2);
        transfer(1, 16'h1234, 16'h3000, 0, 0, 0);
        transfer(0, 16'h0100, 16'h0500, 5, 0, 0);
        transfer(0, 16'h0200, 16'h0900, 40, 0, 0);
        transfer(1, 16'habcd, 16'h4000, 33, 0, 0);
        transfer(0, 16'hfff8, 16'h0010, 20, 0, 0);

        exp_fill = 0; exp_val = 16'h0300; exp_src0 = 16'h0301; exp_dst0 = 16'h0800 - 16'd39;
        rk = 0; wk = 0;
        call(0, 16'h0300, 16'h0800, W'(-40), 1, 0);
        chk(r_intr && wk == 8, "R5", "held irq stops after head", wk, 8);
        chk(pfn == 2, "R4", "prefetch before stop", pfn, 2);
        chk(r_nc == W'(-32) && r_a == 16'h0308, "R6", "stop args", r_a, 16'h0308);

        transfer(0, 16'h0300, 16'h0800, 40, 1, 0);
        transfer(0, 16'h0500, 16'h0a00, 32, 1, 0);
        transfer(1, 16'h7777, 16'h0c00, 50, 1, 0);
        transfer(0, 16'h0600, 16'h0e00, 45, 0, 1);
        transfer(1, 16'h1111, 16'h0f00, 18, 0, 1);

        for (int i = 0; i < 60; i++) begin
            int n;
            n = ($urandom % 5 == 0) ? 16 * int'($urandom % 5) : int'($urandom % 100);
            transfer(1'($urandom % 2), W'($urandom), W'($urandom), n,
                     ($urandom % 2 == 0) ? 2 : 0, 1'($urandom % 6 == 0));
            if (cyc > 150000) begin
                chk(0, "R7", "watchdog expired", cyc, 150000);
                break;
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end
endmodule